// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a SECDED decoder on a memory read path and records memory errors. The decoder reports each error with a correctable strobe or an uncorrectable strobe, together with the upper bits of the failing address and an 8-bit syndrome. The block keeps the first error it sees in one 32-bit status word. The word holds the capture fields, which software can only read. It also holds three enable bits that software can read and write, and two error flags that software clears by writing 1.

Once an error is logged, the record stays frozen until software clears both flags in a single write. While a flag is set, its enable bit turns it into a level request: a correctable error drives an NMI request, and an uncorrectable error drives a bus-error request. One bit of the same word controls write-back scrubbing of corrected reads. A second word holds a test control that forces the stored ECC check bits to zero on memory writes, so that software can inject errors deliberately.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the status word (address 0) and the test word (address 1) both read 0, `scrub_en` is 1, and `nmi_req`, `berr_req` are 0.
- R2: A `ce_stb` with both flags clear sets bit 0 on the next clock edge. The same edge loads bits 30:12 with `err_addr_hi` and bits 11:4 with `err_syn`. Bit 1 stays 0.
- R3: A `ue_stb` with both flags clear sets bit 1 on the next clock edge and loads the address and syndrome fields the same way. Bit 0 stays 0.
- R4: When `ce_stb` and `ue_stb` are high in the same cycle, only bit 1 is set, and the fields take that cycle's address and syndrome.
- R5: While bit 0 or bit 1 is set, any further strobe leaves both flags and both capture fields unchanged. An error of the other kind therefore leaves its flag reading 0.
- R6: A write to address 0 with data bits 1:0 = 2'b11 clears both flags. Data bits 1:0 of 2'b01, 2'b10 or 2'b00 leave the flags unchanged.
- R7: A strobe in the same cycle as a clearing write is captured as a new first error.
- R8: Writes to address 0 load bits 31, 3 and 2 from the write data. Writes never change bits 30:4.
- R9: `nmi_req` is high exactly while bit 0 and bit 2 are both 1. `berr_req` is high exactly while bit 1 and bit 3 are both 1.
- R10: `scrub_en` is the inverse of bit 31.
- R11: Bit 0 of address 1 is read/write. While it is 1, `chk_out` is 0. While it is 0, `chk_out` equals `chk_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_stb | input | 1 | Correctable (single-bit) error strobe |
| ue_stb | input | 1 | Uncorrectable (multi-bit) error strobe |
| err_addr_hi | input | 19 | Upper address bits of the failing access |
| err_syn | input | 8 | Syndrome of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status word, 1 test word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| nmi_req | output | 1 | NMI request for a logged correctable error |
| berr_req | output | 1 | Bus-error request for a logged uncorrectable error |
| scrub_en | output | 1 | Permits write-back of corrected read data |
| chk_in | input | 8 | Check bits from the encoder for a memory write |
| chk_out | output | 8 | Check bits sent to memory |

## Verification
The bench targets the moments when the record must not move. A later error of either kind arrives after the first. A clearing write sets only one flag bit. A strobe coincides with a clearing write. A design that re-armed on a single-flag write, or let a second error overwrite the fields, would show a changed address, syndrome or second flag. A design that dropped the strobe during the clearing write would read back an empty status word. The bench also drives both strobes in one cycle, to catch a design that sets both flags or lets the correctable error win. It toggles each enable with the matching flag set, to catch request outputs that latch instead of following the flag and enable.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
    localparam int LOG_W = 19;
    localparam int SYN_W = 8;
    localparam int CHK_W = 8;
    localparam int SYN_LSB = 4;
    localparam int ADR_LSB = SYN_LSB + SYN_W;
    localparam int SCRB_BIT = ADR_LSB + LOG_W;
    localparam int REG_W = SCRB_BIT + 1;

    typedef struct packed {
        logic             scrub_off;
        logic             berr_en;
        logic             nmi_en;
        logic             force_zero;
    } cfg_t;

    typedef struct packed {
        logic             sbe;
        logic             mbe;
        logic [LOG_W-1:0] addr;
        logic [SYN_W-1:0] syn;
    } rec_t;
endpackage

// File: rtl/ecc_cap_cfg.sv
module ecc_cap_cfg
    import ecc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_status,
    input  logic wr_test,
    input  logic wd_scrub,
    input  logic wd_berr,
    input  logic wd_nmi,
    input  logic wd_force,
    output cfg_t cfg_q
);
    cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_status) begin
            cfg_d.scrub_off = wd_scrub;
            cfg_d.berr_en   = wd_berr;
            cfg_d.nmi_en    = wd_nmi;
        end
        if (wr_test) begin
            cfg_d.force_zero = wd_force;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    p_rw_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> (cfg_q.scrub_off == $past(wd_scrub)) &&
                      (cfg_q.berr_en == $past(wd_berr)) &&
                      (cfg_q.nmi_en == $past(wd_nmi)));

    p_test_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_test |=> $stable(cfg_q.force_zero));
endmodule

// File: rtl/ecc_cap_log.sv
module ecc_cap_log
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_stb,
    input  logic             ue_stb,
    input  logic [LOG_W-1:0] err_addr_hi,
    input  logic [SYN_W-1:0] err_syn,
    input  logic             clr_both,
    output rec_t             rec_q
);
    rec_t rec_d;
    logic locked;
    logic armed;

    always_comb begin
        locked = rec_q.sbe | rec_q.mbe;
        armed  = !locked || clr_both;
        rec_d  = rec_q;
        if (clr_both) begin
            rec_d.sbe = 1'b0;
            rec_d.mbe = 1'b0;
        end
        if (armed && (ce_stb || ue_stb)) begin
            rec_d.mbe  = ue_stb;
            rec_d.sbe  = !ue_stb;
            rec_d.addr = err_addr_hi;
            rec_d.syn  = err_syn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_q.sbe || rec_q.mbe) && !clr_both |=> $stable(rec_q));

    p_ue_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rec_q.sbe || rec_q.mbe) || clr_both) && ue_stb |=> rec_q.mbe && !rec_q.sbe);

    p_ce_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rec_q.sbe || rec_q.mbe) || clr_both) && ce_stb && !ue_stb
            |=> rec_q.sbe && !rec_q.mbe && (rec_q.syn == $past(err_syn)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_both && !ce_stb && !ue_stb |=> !rec_q.sbe && !rec_q.mbe);
endmodule

// File: rtl/ecc_cap_out.sv
module ecc_cap_out
    import ecc_cap_pkg::*;
(
    input  cfg_t             cfg,
    input  rec_t             rec,
    input  logic [CHK_W-1:0] chk_in,
    output logic             nmi_req,
    output logic             berr_req,
    output logic             scrub_en,
    output logic [CHK_W-1:0] chk_out
);
    always_comb begin
        nmi_req  = rec.sbe & cfg.nmi_en;
        berr_req = rec.mbe & cfg.berr_en;
        scrub_en = !cfg.scrub_off;
        chk_out  = cfg.force_zero ? '0 : chk_in;
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_stb,
    input  logic                   ue_stb,
    input  logic [LOG_W-1:0]       err_addr_hi,
    input  logic [SYN_W-1:0]       err_syn,
    input  logic                   reg_wr,
    input  logic                   reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    output logic                   nmi_req,
    output logic                   berr_req,
    output logic                   scrub_en,
    input  logic [CHK_W-1:0]       chk_in,
    output logic [CHK_W-1:0]       chk_out
);
    cfg_t cfg_q;
    rec_t rec_q;
    logic wr_status;
    logic wr_test;
    logic clr_both;

    always_comb begin
        wr_status = reg_wr && !reg_addr;
        wr_test   = reg_wr && reg_addr;
        clr_both  = wr_status && (reg_wdata[1:0] == 2'b11);
    end

    ecc_cap_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_status (wr_status),
        .wr_test   (wr_test),
        .wd_scrub  (reg_wdata[SCRB_BIT]),
        .wd_berr   (reg_wdata[3]),
        .wd_nmi    (reg_wdata[2]),
        .wd_force  (reg_wdata[0]),
        .cfg_q     (cfg_q)
    );

    ecc_cap_log u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_stb      (ce_stb),
        .ue_stb      (ue_stb),
        .err_addr_hi (err_addr_hi),
        .err_syn     (err_syn),
        .clr_both    (clr_both),
        .rec_q       (rec_q)
    );

    ecc_cap_out u_out (
        .cfg      (cfg_q),
        .rec      (rec_q),
        .chk_in   (chk_in),
        .nmi_req  (nmi_req),
        .berr_req (berr_req),
        .scrub_en (scrub_en),
        .chk_out  (chk_out)
    );

    always_comb begin
        if (reg_addr) begin
            reg_rdata    = '0;
            reg_rdata[0] = cfg_q.force_zero;
        end else begin
            reg_rdata = {cfg_q.scrub_off, rec_q.addr, rec_q.syn,
                         cfg_q.berr_en, cfg_q.nmi_en, rec_q.mbe, rec_q.sbe};
        end
    end

    p_irq_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req && berr_req));

    p_ro_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status && !ce_stb && !ue_stb |=> $stable(rec_q.addr) && $stable(rec_q.syn));
endmodule

// File: tb/ecc_err_capture_tb_top.sv
module ecc_err_capture_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        ce_stb = 0, ue_stb = 0;
    logic [18:0] err_addr_hi = '0;
    logic [7:0]  err_syn = '0;
    logic        reg_wr = 0, reg_addr = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req, berr_req, scrub_en;
    logic [7:0]  chk_in = '0, chk_out;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    ecc_err_capture dut_i (
        .clk(clk), .rst_n(rst_n), .ce_stb(ce_stb), .ue_stb(ue_stb),
        .err_addr_hi(err_addr_hi), .err_syn(err_syn),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .nmi_req(nmi_req), .berr_req(berr_req),
        .scrub_en(scrub_en), .chk_in(chk_in), .chk_out(chk_out)
    );

    function automatic logic [31:0] word(logic sc, logic [18:0] a, logic [7:0] s,
                                         logic be, logic ne, logic mb, logic sb);
        return {sc, a, s, be, ne, mb, sb};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd_status(output logic [31:0] v);
        reg_addr = 0; #1 v = reg_rdata;
    endtask

    task automatic wr(logic a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; cyc();
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    endtask

    task automatic strobe(logic ce, logic ue, logic [18:0] a, logic [7:0] s);
        ce_stb = ce; ue_stb = ue; err_addr_hi = a; err_syn = s; cyc();
        ce_stb = 0; ue_stb = 0;
    endtask

    task automatic clear_all();
        wr(0, 32'h0000_0003);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_status(v); chk("R1 status", v, 0);
        reg_addr = 1; #1 chk("R1 test word", reg_rdata, 0); reg_addr = 0;
        chk("R1 outputs", {nmi_req, berr_req, scrub_en}, 3'b001);
    endtask

    task automatic t_ce();
        logic [31:0] v;
        strobe(1, 0, 19'h5A5A5, 8'h3C);
        rd_status(v); chk("R2 ce capture", v, word(0, 19'h5A5A5, 8'h3C, 0, 0, 0, 1));
        clear_all();
    endtask

    task automatic t_ue();
        logic [31:0] v;
        strobe(0, 1, 19'h00F0F, 8'hC3);
        rd_status(v); chk("R3 ue capture", v, word(0, 19'h00F0F, 8'hC3, 0, 0, 1, 0));
        clear_all();
    endtask

    task automatic t_both();
        logic [31:0] v;
        strobe(1, 1, 19'h7FFFF, 8'hFF);
        rd_status(v); chk("R4 ue wins", v, word(0, 19'h7FFFF, 8'hFF, 0, 0, 1, 0));
        clear_all();
        rd_status(v); chk("R6 cleared", v[1:0], 0);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        strobe(1, 0, 19'h11111, 8'h11);
        strobe(0, 1, 19'h22222, 8'h22);
        rd_status(v); chk("R5 ue after ce", v, word(0, 19'h11111, 8'h11, 0, 0, 0, 1));
        strobe(1, 0, 19'h33333, 8'h33);
        rd_status(v); chk("R5 ce after ce", v, word(0, 19'h11111, 8'h11, 0, 0, 0, 1));
        clear_all();
    endtask

    task automatic t_partial();
        logic [31:0] v;
        strobe(0, 1, 19'h0ABCD, 8'h5E);
        wr(0, 32'h0000_0002);
        rd_status(v); chk("R6 write 10", v, word(0, 19'h0ABCD, 8'h5E, 0, 0, 1, 0));
        wr(0, 32'h0000_0001);
        rd_status(v); chk("R6 write 01", v, word(0, 19'h0ABCD, 8'h5E, 0, 0, 1, 0));
        wr(0, 32'h0000_0000);
        rd_status(v); chk("R6 write 00", v[1:0], 2'b10);
        clear_all();
        rd_status(v); chk("R6 write 11", v, word(0, 19'h0ABCD, 8'h5E, 0, 0, 0, 0));
    endtask

    task automatic t_clr_strobe();
        logic [31:0] v;
        strobe(1, 0, 19'h01234, 8'h01);
        reg_wr = 1; reg_addr = 0; reg_wdata = 32'h3;
        ce_stb = 1; err_addr_hi = 19'h45678; err_syn = 8'h9A; cyc();
        reg_wr = 0; reg_wdata = 0; ce_stb = 0;
        rd_status(v); chk("R7 capture on clear", v, word(0, 19'h45678, 8'h9A, 0, 0, 0, 1));
        clear_all();
    endtask

    task automatic t_rw();
        logic [31:0] v;
        strobe(1, 0, 19'h2468A, 8'h77);
        clear_all();
        wr(0, 32'hFFFF_FFFC);
        rd_status(v); chk("R8 rw bits set, ro kept", v, word(1, 19'h2468A, 8'h77, 1, 1, 0, 0));
        chk("R10 scrub off", scrub_en, 0);
        wr(0, 32'h0000_0000);
        rd_status(v); chk("R8 rw bits clear", v, word(0, 19'h2468A, 8'h77, 0, 0, 0, 0));
        chk("R10 scrub on", scrub_en, 1);
    endtask

    task automatic t_irq();
        #1 chk("R9 idle", {nmi_req, berr_req}, 0);
        wr(0, 32'h0000_000C);
        strobe(1, 0, 19'h1, 8'h1);
        #1 chk("R9 nmi on", {nmi_req, berr_req}, 2'b10);
        wr(0, 32'h0000_0008);
        #1 chk("R9 nmi enable off", {nmi_req, berr_req}, 2'b00);
        wr(0, 32'h0000_000F);
        #1 chk("R9 after clear", {nmi_req, berr_req}, 2'b00);
        strobe(0, 1, 19'h2, 8'h2);
        #1 chk("R9 berr on", {nmi_req, berr_req}, 2'b01);
        wr(0, 32'h0000_0004);
        #1 chk("R9 berr enable off", {nmi_req, berr_req}, 2'b00);
        wr(0, 32'h0000_0003);
    endtask

    task automatic t_force();
        chk_in = 8'hA5; #1 chk("R11 pass", chk_out, 8'hA5);
        wr(1, 32'h1);
        reg_addr = 1; #1 chk("R11 readback", reg_rdata, 1); reg_addr = 0;
        chk("R11 forced", chk_out, 0);
        wr(1, 32'h0);
        #1 chk("R11 released", chk_out, 8'hA5);
    endtask

    initial begin
        fork
            begin
                repeat (3) cyc();
                rst_n = 1; cyc();
                t_reset(); t_ce(); t_ue(); t_both(); t_freeze();
                t_partial(); t_clr_strobe(); t_rw(); t_irq(); t_force();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule